// File: doc/BRIEF.md
# RTC Alarm Match Interrupt

This block watches the live calendar of a real-time clock (weekday, hour, minute) and compares it with a programmed alarm setting. The setting is a per-weekday select mask plus an hour and a minute. When the alarm is armed and the calendar enters a matching minute, the block latches an alarm flag on the next pulse of the internal time-base tick. The active-low interrupt pin then falls. The readable flag always shows the opposite level of the pin.

Software programs the alarm values while the alarm is disarmed, then arms it through an enable write. The interrupt stays low until software writes a 0 to the flag or disarms the alarm. A flag clear leaves the alarm armed, so it fires again on the next matching minute. Disarming releases the pin on the next clock edge and blocks any further firing. Firing is edge-based: an alarm armed in the middle of a matching minute waits for the next match.

The host bus, the calendar counters and the time base are outside this block. It receives the calendar values, a one-cycle minute strobe that marks each calendar update, and a one-cycle time-base tick.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset the pin `irq_n_o` is 1, `flag_o` is 0 and the alarm is disarmed, so a matching calendar with ticks does not fire until the enable is written to 1.
- R2: With the alarm armed, a tick cycle in which the calendar newly matches sets the flag at that clock edge. The pin is low from the next cycle on and stays low until it is cleared.
- R3: The flag is only set at a tick. A matching calendar without a tick leaves the pin high.
- R4: The weekday matches only when bit `cur_wday_i` of `alm_wday_mask_i` is 1 (bit 0 is weekday code 0). With that bit 0, a matching hour and minute do not fire.
- R5: A calendar whose hour or minute differs from the alarm does not fire.
- R6: Writing the flag with data 0 releases the pin on the next cycle, and it stays released for the rest of the matching minute. The alarm stays armed and fires again on the next matching minute.
- R7: Writing the flag with data 1 has no effect.
- R8: Writing the enable with data 0 releases the pin on the next cycle. No further firing happens while the alarm is disarmed.
- R9: Arming the alarm while the calendar already matches does not fire in that minute.
- R10: `flag_o` is always the inverse of `irq_n_o`.
- R11: When a firing event and a flag clear write fall in the same cycle, the event wins and the pin goes low. When an event and a disarm write fall in the same cycle, the disarm wins and the pin stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Internal time-base tick, one cycle wide |
| min_strobe_i | input | 1 | One-cycle pulse when the calendar moves to a new minute |
| alm_wday_mask_i | input | DAYS (7) | Weekday select mask, bit n for weekday code n |
| alm_hour_i | input | HOUR_W (5) | Alarm hour |
| alm_min_i | input | MIN_W (6) | Alarm minute |
| en_wr_i | input | 1 | Enable write strobe |
| en_wdata_i | input | 1 | Enable write data |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 1 | Flag write data (0 clears, 1 ignored) |
| cur_wday_i | input | WDAY_W (3) | Current weekday code |
| cur_hour_i | input | HOUR_W (5) | Current hour |
| cur_min_i | input | MIN_W (6) | Current minute |
| irq_n_o | output | 1 | Active-low alarm interrupt |
| flag_o | output | 1 | Readable alarm flag, inverse of the pin |

## Verification
The bench builds the block with its default parameters: seven weekdays, a five-bit hour, a six-bit minute and a two-stage reset synchronizer. These values let it exercise single-bit weekday selection against neighbouring weekday codes. They also bring into reach the late-arm case, the clear inside a matching minute, and both same-cycle collisions. Every expected pin and flag level is checked one edge after the stimulus that causes it.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int unsigned DEF_DAYS   = 7;
  localparam int unsigned DEF_HOUR_W = 5;
  localparam int unsigned DEF_MIN_W  = 6;

  // Update applied to the alarm flag in one cycle
  typedef enum logic [1:0] {
    FLAG_HOLD = 2'd0,
    FLAG_SET  = 2'd1,
    FLAG_CLR  = 2'd2
  } flag_op_e;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned DAYS   = 7,
  parameter int unsigned HOUR_W = 5,
  parameter int unsigned MIN_W  = 6,
  localparam int unsigned WDAY_W = (DAYS > 1) ? $clog2(DAYS) : 1
) (
  input  logic [DAYS-1:0]   wday_mask_i,
  input  logic [HOUR_W-1:0] alm_hour_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  output logic              hit_o
);

  logic [DAYS-1:0] day_hit;
  logic            hour_eq;
  logic            min_eq;

  // one decoder slice per weekday
  for (genvar d = 0; d < DAYS; d++) begin : g_day
    assign day_hit[d] = wday_mask_i[d] && (cur_wday_i == WDAY_W'(d));
  end

  assign hour_eq = (cur_hour_i == alm_hour_i);
  assign min_eq  = (cur_min_i == alm_min_i);
  assign hit_o   = (|day_hit) && hour_eq && min_eq;

endmodule

// File: rtl/rtc_alarm_edge.sv
module rtc_alarm_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic min_strobe_i,
  input  logic hit_i,
  output logic event_o
);

  logic hit_q, hit_d;
  logic fresh_q, fresh_d;

  // hit is sampled on ticks only; fresh marks a calendar update not yet seen by a tick
  always_comb begin
    hit_d   = hit_q;
    fresh_d = fresh_q;
    if (tick_i) begin
      hit_d   = hit_i;
      fresh_d = 1'b0;
    end else if (min_strobe_i) begin
      fresh_d = 1'b1;
    end
  end

  assign event_o = tick_i && hit_i && (!hit_q || fresh_q || min_strobe_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q   <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      fresh_q <= fresh_d;
    end
  end

endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
  import rtc_alarm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic en_wr_i,
  input  logic en_wdata_i,
  input  logic flag_wr_i,
  input  logic flag_wdata_i,
  output logic flag_o
);

  logic     en_q, en_d;
  logic     flag_q, flag_d;
  flag_op_e op;

  // priority: disarm, then event, then host clear
  always_comb begin
    op = FLAG_HOLD;
    if (en_wr_i && !en_wdata_i)          op = FLAG_CLR;
    else if (event_i && en_q)            op = FLAG_SET;
    else if (flag_wr_i && !flag_wdata_i) op = FLAG_CLR;
  end

  always_comb begin
    en_d = en_q;
    if (en_wr_i) en_d = en_wdata_i;
    unique case (op)
      FLAG_SET: flag_d = 1'b1;
      FLAG_CLR: flag_d = 1'b0;
      default:  flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int unsigned DAYS       = rtc_alarm_pkg::DEF_DAYS,
  parameter int unsigned HOUR_W     = rtc_alarm_pkg::DEF_HOUR_W,
  parameter int unsigned MIN_W      = rtc_alarm_pkg::DEF_MIN_W,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned WDAY_W    = (DAYS > 1) ? $clog2(DAYS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              min_strobe_i,
  input  logic [DAYS-1:0]   alm_wday_mask_i,
  input  logic [HOUR_W-1:0] alm_hour_i,
  input  logic [MIN_W-1:0]  alm_min_i,
  input  logic              en_wr_i,
  input  logic              en_wdata_i,
  input  logic              flag_wr_i,
  input  logic              flag_wdata_i,
  input  logic [WDAY_W-1:0] cur_wday_i,
  input  logic [HOUR_W-1:0] cur_hour_i,
  input  logic [MIN_W-1:0]  cur_min_i,
  output logic              irq_n_o,
  output logic              flag_o
);

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  hit;
  logic                  evt;
  logic                  flag;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  rtc_alarm_cmp #(
    .DAYS   (DAYS),
    .HOUR_W (HOUR_W),
    .MIN_W  (MIN_W)
  ) i_cmp (
    .wday_mask_i (alm_wday_mask_i),
    .alm_hour_i  (alm_hour_i),
    .alm_min_i   (alm_min_i),
    .cur_wday_i  (cur_wday_i),
    .cur_hour_i  (cur_hour_i),
    .cur_min_i   (cur_min_i),
    .hit_o       (hit)
  );

  rtc_alarm_edge i_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .tick_i       (tick_i),
    .min_strobe_i (min_strobe_i),
    .hit_i        (hit),
    .event_o      (evt)
  );

  rtc_alarm_ctl i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .event_i      (evt),
    .en_wr_i      (en_wr_i),
    .en_wdata_i   (en_wdata_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .flag_o       (flag)
  );

  assign irq_n_o = ~flag;
  assign flag_o  = flag;

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic en_wr_i,
  input logic en_wdata_i,
  input logic flag_wr_i,
  input logic flag_wdata_i,
  input logic irq_n_o,
  input logic flag_o
);

  AST_FALL_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_n_o) |-> $past(tick_i)); // R3

  AST_DISARM_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_wr_i && !en_wdata_i) |=> irq_n_o); // R8

  AST_CLEAR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_wr_i && !flag_wdata_i && !tick_i) |=> irq_n_o); // R6

  AST_LOW_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_n_o && !(flag_wr_i && !flag_wdata_i) && !(en_wr_i && !en_wdata_i)) |=> !irq_n_o); // R2

  AST_FLAG_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o != irq_n_o); // R10

endmodule

bind rtc_alarm_irq rtc_alarm_chk i_rtc_alarm_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .en_wr_i      (en_wr_i),
  .en_wdata_i   (en_wdata_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .irq_n_o      (irq_n_o),
  .flag_o       (flag_o)
);

// File: tb/test_rtc_alarm_irq.sv
`timescale 1ns/1ps
module test_rtc_alarm_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, min_strobe = 1'b0;
  logic [6:0] mask = 7'b0001000;
  logic [4:0] alm_hour = 5'd7, cur_hour = 5'd7;
  logic [5:0] alm_min = 6'd30, cur_min = 6'd30;
  logic [2:0] cur_wday = 3'd3;
  logic       en_wr = 1'b0, en_wdata = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic       irq_n, flag;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { string tag; logic irq_n; } exp_t;
  exp_t q[$];

  always #2 clk = ~clk; // 250 MHz

  rtc_alarm_irq i_rtc_alarm_irq (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .min_strobe_i(min_strobe),
    .alm_wday_mask_i(mask), .alm_hour_i(alm_hour), .alm_min_i(alm_min),
    .en_wr_i(en_wr), .en_wdata_i(en_wdata), .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .cur_wday_i(cur_wday), .cur_hour_i(cur_hour), .cur_min_i(cur_min),
    .irq_n_o(irq_n), .flag_o(flag)
  );

  // driver: expectation for the outputs after the next rising edge
  task automatic cyc(input string tag, input logic exp_irq_n);
    exp_t e;
    e.tag = tag;
    e.irq_n = exp_irq_n;
    q.push_back(e);
    @(negedge clk);
    tick = 1'b0; min_strobe = 1'b0; en_wr = 1'b0; flag_wr = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (irq_n !== e.irq_n || flag !== !e.irq_n) begin
          n_fail++;
          $display("FAIL %s: irq_n=%b flag=%b expected irq_n=%b flag=%b (R10 polarity)",
                   e.tag, irq_n, flag, e.irq_n, !e.irq_n);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc("R1 reset state", 1'b1);
    cyc("R1 reset state", 1'b1);
    cyc("R1 reset state", 1'b1);
    tick = 1'b1;
    cyc("R1 disarmed after reset", 1'b1);
    en_wr = 1'b1; en_wdata = 1'b1;
    cyc("R9 arm inside matching minute", 1'b1);
    tick = 1'b1;
    cyc("R9 no fire after late arm", 1'b1);
    cur_min = 6'd31; min_strobe = 1'b1; tick = 1'b1;
    cyc("R5 minute mismatch", 1'b1);
    cur_min = 6'd30; min_strobe = 1'b1;
    cyc("R3 no fire before tick", 1'b1);
    tick = 1'b1;
    cyc("R2 fire on tick", 1'b0);
    cyc("R2 pin held low", 1'b0);
    flag_wr = 1'b1; flag_wdata = 1'b1;
    cyc("R7 flag write 1 ignored", 1'b0);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    cyc("R6 flag clear releases", 1'b1);
    tick = 1'b1;
    cyc("R6 released for rest of minute", 1'b1);
    cur_min = 6'd31; min_strobe = 1'b1; tick = 1'b1;
    cyc("R5 minute mismatch", 1'b1);
    cur_min = 6'd30; min_strobe = 1'b1; tick = 1'b1;
    cyc("R6 fires again next match", 1'b0);
    en_wr = 1'b1; en_wdata = 1'b0;
    cyc("R8 disarm releases", 1'b1);
    cur_min = 6'd31; min_strobe = 1'b1; tick = 1'b1;
    cyc("R8 away", 1'b1);
    cur_min = 6'd30; min_strobe = 1'b1; tick = 1'b1;
    cyc("R8 blocked while disarmed", 1'b1);
    en_wr = 1'b1; en_wdata = 1'b1;
    cyc("R8 rearm", 1'b1);
    cur_min = 6'd31; min_strobe = 1'b1; tick = 1'b1;
    cyc("R5 away", 1'b1);
    cur_wday = 3'd2; cur_min = 6'd30; min_strobe = 1'b1; tick = 1'b1;
    cyc("R4 weekday bit not in mask", 1'b1);
    cur_wday = 3'd4; min_strobe = 1'b1; tick = 1'b1;
    cyc("R4 neighbour weekday not in mask", 1'b1);
    cur_wday = 3'd3; cur_hour = 5'd8; min_strobe = 1'b1; tick = 1'b1;
    cyc("R5 hour mismatch", 1'b1);
    cur_hour = 5'd7; min_strobe = 1'b1; tick = 1'b1; flag_wr = 1'b1; flag_wdata = 1'b0;
    cyc("R11 event beats flag clear", 1'b0);
    flag_wr = 1'b1; flag_wdata = 1'b0;
    cyc("R6 clear", 1'b1);
    cur_min = 6'd31; min_strobe = 1'b1; tick = 1'b1;
    cyc("R11 away", 1'b1);
    cur_min = 6'd30; min_strobe = 1'b1; tick = 1'b1; en_wr = 1'b1; en_wdata = 1'b0;
    cyc("R11 disarm beats event", 1'b1);
    cyc("R11 stays released", 1'b1);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule